// File: doc/BRIEF.md
# Three-Level Priority Interrupt Controller

This block gathers interrupt requests from up to eight sources into a pending register. Software gives each source a priority by writing two enable registers. The "high" bit and the "low" bit of a source together select disabled, low, medium or high. When the global enable input is set, the controller picks the most urgent pending source that is enabled. It drives a request line and a source index to the processor, which answers with a one-cycle acknowledge.

When the global enable is clear, no request reaches the processor. Software then polls the pending register over the register bus and clears bits by writing ones to them. A second, narrower pending register latches four port-pin events. Software only polls this register; the arbiter never sees it.

Top module: `icx_ctrl`

## Requirements
- R1: A high level on `src_req[i]` at a clock edge sets pending bit i of the main request register (address 0). The bit stays set until software or an acknowledge clears it.
- R2: The priority of source i is {hi[i], lo[i]}, where hi is the register at address 1 and lo is the register at address 2. 00 means disabled, 01 low, 10 medium and 11 high. Both registers are plain read/write.
- R3: Among pending, enabled sources, the highest priority level is selected. Within one level, the lowest source number is selected.
- R4: A source with priority 00 still sets its pending bit but never causes `cpu_irq` to rise.
- R5: While `gie` is low, `cpu_irq` is 0 one cycle later and `cpu_idx` is 0. The pending register stays readable, so software can poll it.
- R6: Writing the main request register clears each bit written as 1. Bits written as 0 are unchanged.
- R7: When `cpu_ack` is high while `cpu_irq` is high, the pending bit named by `cpu_idx` is cleared at that edge.
- R8: If a new request and a clear (by write or by acknowledge) hit the same bit in the same cycle, the bit ends up set.
- R9: The pin request register (address 3) latches `pin_req[3:0]` into bits 3:0. Writing 1 to one of these bits clears it. Bits 7:4 always read 0 and ignore writes. This register never raises `cpu_irq`.
- R10: After reset, all four registers read 0 and `cpu_irq` is 0.
- R11: `cpu_irq` and `cpu_idx` are registered. They reflect the pending and enable state one clock after that state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| src_req | input | 8 | Request inputs of the arbitrated sources |
| pin_req | input | 4 | Port-pin request inputs, polled only |
| gie | input | 1 | Global interrupt enable |
| cpu_ack | input | 1 | Acknowledge of the presented interrupt |
| cpu_irq | output | 1 | Interrupt request to the processor |
| cpu_idx | output | 3 | Index of the selected source |

## Verification
The bench sweeps every non-empty pending pattern against five priority maps and predicts the winner arithmetically. One map puts every source at the same level. A design that inverted the tie order, or that let a lower level beat a higher one, would report the wrong index there. Separate cases target a disabled source that is pending, polling with `gie` low, and acknowledge followed by re-arbitration. They also cover a set and a clear landing on the same bit in the same cycle, where a design that lets the clear win would lose a request. Further cases check writes to the reserved pin-register bits, which a design without masking would read back as nonzero. Another case samples the request one cycle after capture, and would catch an unregistered or doubly registered output.

// File: rtl/icx_pkg.sv
package icx_pkg;

    typedef enum logic [1:0] {
        PRIO_OFF  = 2'b00,
        PRIO_LOW  = 2'b01,
        PRIO_MED  = 2'b10,
        PRIO_HIGH = 2'b11
    } prio_e;

    localparam logic [1:0] ADDR_REQ = 2'd0;
    localparam logic [1:0] ADDR_HI  = 2'd1;
    localparam logic [1:0] ADDR_LO  = 2'd2;
    localparam logic [1:0] ADDR_PIN = 2'd3;

endpackage

// File: rtl/icx_req_next.sv
// Next value of a pending register: a set wins over a clear on the same bit.
module icx_req_next #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] nxt
);
    always_comb begin
        nxt = (cur & ~clr) | set;
    end
endmodule

// File: rtl/icx_prio_pick.sv
// Picks the pending source with the highest level; lowest index on ties.
module icx_prio_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  pend,
    input  logic [N-1:0]  hi,
    input  logic [N-1:0]  lo,
    output logic          found,
    output logic [IW-1:0] idx
);
    import icx_pkg::*;

    logic [1:0] lvl [N];

    generate
        for (genvar g = 0; g < N; g++) begin : g_lvl
            assign lvl[g] = pend[g] ? {hi[g], lo[g]} : 2'(PRIO_OFF);
        end
    endgenerate

    logic [1:0] best;

    always_comb begin
        best = 2'(PRIO_OFF);
        idx  = '0;
        // Scan from the top index down; ">=" lets a lower index take a tie.
        for (int i = N - 1; i >= 0; i--) begin
            if (lvl[i] != 2'(PRIO_OFF) && lvl[i] >= best) begin
                best = lvl[i];
                idx  = IW'(i);
            end
        end
        found = (best != 2'(PRIO_OFF));
    end
endmodule

// File: rtl/icx_rd_mux.sv
module icx_rd_mux #(
    parameter int NSRC = 8,
    parameter int NPIN = 4,
    parameter int DW   = 8,
    parameter int AW   = 2
) (
    input  logic [AW-1:0]   addr,
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] hi,
    input  logic [NSRC-1:0] lo,
    input  logic [NPIN-1:0] pin,
    output logic [DW-1:0]   rdata
);
    import icx_pkg::*;

    always_comb begin
        unique case (addr)
            AW'(ADDR_REQ): rdata = DW'(req);
            AW'(ADDR_HI):  rdata = DW'(hi);
            AW'(ADDR_LO):  rdata = DW'(lo);
            default:       rdata = DW'(pin);
        endcase
    end
endmodule

// File: rtl/icx_ctrl.sv
module icx_ctrl #(
    parameter int NSRC = 8,
    parameter int NPIN = 4,
    parameter int DW   = 8,
    parameter int AW   = 2,
    localparam int IW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NSRC-1:0] src_req,
    input  logic [NPIN-1:0] pin_req,
    input  logic            gie,
    input  logic            cpu_ack,
    output logic            cpu_irq,
    output logic [IW-1:0]   cpu_idx
);
    import icx_pkg::*;

    typedef struct packed {
        logic [NSRC-1:0] req;
        logic [NSRC-1:0] hi;
        logic [NSRC-1:0] lo;
        logic [NPIN-1:0] pin;
        logic            irq;
        logic [IW-1:0]   idx;
    } state_t;

    state_t st_d, st_q;

    // Write decode
    logic wr_req_d, wr_hi_d, wr_lo_d, wr_pin_d;
    always_comb begin
        wr_req_d = bus_we && (bus_addr == AW'(ADDR_REQ));
        wr_hi_d  = bus_we && (bus_addr == AW'(ADDR_HI));
        wr_lo_d  = bus_we && (bus_addr == AW'(ADDR_LO));
        wr_pin_d = bus_we && (bus_addr == AW'(ADDR_PIN));
    end

    // Clear masks: software write-one plus acknowledge of the presented source
    logic [NSRC-1:0] ack_mask_d, req_clr_d, req_nxt_d;
    logic [NPIN-1:0] pin_clr_d, pin_nxt_d;
    always_comb begin
        ack_mask_d = (cpu_ack && st_q.irq) ? (NSRC'(1) << st_q.idx) : '0;
        req_clr_d  = (wr_req_d ? bus_wdata[NSRC-1:0] : '0) | ack_mask_d;
        pin_clr_d  = wr_pin_d ? bus_wdata[NPIN-1:0] : '0;
    end

    icx_req_next #(.W(NSRC)) u_req_next (
        .cur (st_q.req),
        .set (src_req),
        .clr (req_clr_d),
        .nxt (req_nxt_d)
    );

    icx_req_next #(.W(NPIN)) u_pin_next (
        .cur (st_q.pin),
        .set (pin_req),
        .clr (pin_clr_d),
        .nxt (pin_nxt_d)
    );

    // Arbitration over the registered state
    logic          pick_found_d;
    logic [IW-1:0] pick_idx_d;

    icx_prio_pick #(.N(NSRC), .IW(IW)) u_pick (
        .pend  (st_q.req),
        .hi    (st_q.hi),
        .lo    (st_q.lo),
        .found (pick_found_d),
        .idx   (pick_idx_d)
    );

    always_comb begin
        st_d     = st_q;
        st_d.req = req_nxt_d;
        st_d.pin = pin_nxt_d;
        if (wr_hi_d) st_d.hi = bus_wdata[NSRC-1:0];
        if (wr_lo_d) st_d.lo = bus_wdata[NSRC-1:0];
        st_d.irq = gie && pick_found_d;
        st_d.idx = (gie && pick_found_d) ? pick_idx_d : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    icx_rd_mux #(.NSRC(NSRC), .NPIN(NPIN), .DW(DW), .AW(AW)) u_rd (
        .addr  (bus_addr),
        .req   (st_q.req),
        .hi    (st_q.hi),
        .lo    (st_q.lo),
        .pin   (st_q.pin),
        .rdata (bus_rdata)
    );

    assign cpu_irq = st_q.irq;
    assign cpu_idx = st_q.idx;

    // Internal views for the bound checker
    logic [NSRC-1:0] req_vec, hi_vec, lo_vec;
    assign req_vec = st_q.req;
    assign hi_vec  = st_q.hi;
    assign lo_vec  = st_q.lo;

endmodule

// File: rtl/icx_ctrl_chk.sv
module icx_ctrl_chk #(
    parameter int NSRC = 8,
    parameter int NPIN = 4,
    parameter int DW   = 8,
    parameter int AW   = 2,
    parameter int IW   = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            gie,
    input logic            bus_we,
    input logic [AW-1:0]   bus_addr,
    input logic [DW-1:0]   bus_wdata,
    input logic [DW-1:0]   bus_rdata,
    input logic [NSRC-1:0] src_req,
    input logic            cpu_ack,
    input logic            cpu_irq,
    input logic [IW-1:0]   cpu_idx,
    input logic [NSRC-1:0] req_vec,
    input logic [NSRC-1:0] hi_vec,
    input logic [NSRC-1:0] lo_vec
);
    import icx_pkg::*;

    assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_req) |=> ((req_vec & $past(src_req)) == $past(src_req)));

    assert_sel_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> ((($past(req_vec & (hi_vec | lo_vec))) >> cpu_idx) & NSRC'(1)) != '0);

    assert_polled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |=> !cpu_irq);

    assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(ADDR_REQ))
        |=> ((req_vec & $past(bus_wdata[NSRC-1:0] & ~src_req)) == '0));

    assert_ack_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && cpu_irq && (((src_req >> cpu_idx) & NSRC'(1)) == '0))
        |=> (((req_vec >> $past(cpu_idx)) & NSRC'(1)) == '0));

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(ADDR_REQ) && |(bus_wdata[NSRC-1:0] & src_req))
        |=> ((req_vec & $past(bus_wdata[NSRC-1:0] & src_req)) != '0));

    assert_pin_resv_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == AW'(ADDR_PIN)) |-> (bus_rdata[DW-1:NPIN] == '0));

endmodule

bind icx_ctrl icx_ctrl_chk #(
    .NSRC(NSRC), .NPIN(NPIN), .DW(DW), .AW(AW), .IW(IW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gie       (gie),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_req   (src_req),
    .cpu_ack   (cpu_ack),
    .cpu_irq   (cpu_irq),
    .cpu_idx   (cpu_idx),
    .req_vec   (req_vec),
    .hi_vec    (hi_vec),
    .lo_vec    (lo_vec)
);

// File: tb/tb_icx_ctrl.sv
`timescale 1ns/1ps
module tb_icx_ctrl;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       bus_we = 0;
    logic [1:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic [7:0] src_req = 0;
    logic [3:0] pin_req = 0;
    logic       gie = 0;
    logic       cpu_ack = 0;
    logic       cpu_irq;
    logic [2:0] cpu_idx;

    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    icx_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_req(src_req),
        .pin_req(pin_req), .gie(gie), .cpu_ack(cpu_ack),
        .cpu_irq(cpu_irq), .cpu_idx(cpu_idx)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [7:0] v);
        @(negedge clk);
        src_req = v;
        @(negedge clk);
        src_req = 0;
    endtask

    // Expected winner: scan levels high to low, sources low to high
    function automatic int exp_pick(input logic [7:0] pend, input logic [7:0] hi, input logic [7:0] lo);
        for (int lv = 3; lv >= 1; lv--)
            for (int i = 0; i < 8; i++)
                if (pend[i] && (2 * int'(hi[i]) + int'(lo[i])) == lv) return i;
        return -1;
    endfunction

    function automatic logic [15:0] cfg_map(input int c);
        logic [7:0] hi, lo;
        for (int i = 0; i < 8; i++) begin
            int lv;
            lv = (c == 4) ? 3 : ((i * (c + 1) + c) % 4);
            hi[i] = lv[1];
            lo[i] = lv[0];
        end
        return {hi, lo};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        nchk++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [15:0] m;
        int e;

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R10: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            check(d == 0, "R10 reg reset", d, 0);
        end
        check(cpu_irq == 0, "R10 irq reset", cpu_irq, 0);

        // R11: registered output, one cycle after capture
        gie = 1;
        wr(2'd1, 8'hFF);
        wr(2'd2, 8'hFF);
        pulse(8'h08);
        check(cpu_irq == 0, "R11 irq not yet", cpu_irq, 0);
        @(negedge clk);
        check(cpu_irq == 1 && cpu_idx == 3, "R11 irq one cycle later", {cpu_irq, cpu_idx}, 8 + 3);

        // R1 R2 R3: sweep every pending pattern over five priority maps
        for (int c = 0; c < 5; c++) begin
            m = cfg_map(c);
            wr(2'd1, m[15:8]);
            wr(2'd2, m[7:0]);
            for (int p = 1; p < 256; p++) begin
                wr(2'd0, 8'hFF);
                pulse(8'(p));
                @(negedge clk);
                e = exp_pick(8'(p), m[15:8], m[7:0]);
                if (e < 0)
                    check(cpu_irq == 0, "R2 R3 none enabled", cpu_irq, 0);
                else
                    check(cpu_irq == 1 && int'(cpu_idx) == e, "R3 winner",
                          cpu_irq ? int'(cpu_idx) : -1, e);
                rd(2'd0, d);
                check(d == 8'(p), "R1 pending held", d, p);
            end
        end

        // R4: disabled sources pend but stay silent
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h00);
        pulse(8'hFF);
        repeat (2) @(negedge clk);
        check(cpu_irq == 0, "R4 disabled silent", cpu_irq, 0);
        rd(2'd0, d);
        check(d == 8'hFF, "R4 disabled still pends", d, 8'hFF);
        wr(2'd1, 8'h20);
        @(negedge clk);
        check(cpu_irq == 1 && cpu_idx == 5, "R4 enabled source 5 medium", cpu_idx, 5);

        // R5: polled mode
        gie = 0;
        repeat (2) @(negedge clk);
        check(cpu_irq == 0, "R5 gie off", cpu_irq, 0);
        check(cpu_idx == 0, "R5 idx zero", cpu_idx, 0);
        rd(2'd0, d);
        check(d == 8'hFF, "R5 poll readable", d, 8'hFF);
        gie = 1;
        repeat (2) @(negedge clk);
        check(cpu_irq == 1, "R5 gie back on", cpu_irq, 1);

        // R6: write-one-to-clear
        wr(2'd0, 8'h0F);
        rd(2'd0, d);
        check(d == 8'hF0, "R6 w1c", d, 8'hF0);
        wr(2'd0, 8'h00);
        rd(2'd0, d);
        check(d == 8'hF0, "R6 zero no effect", d, 8'hF0);

        // R7: acknowledge clears selected bit and re-arbitrates
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'hFF);
        wr(2'd2, 8'hFF);
        pulse(8'hA4);
        @(negedge clk);
        check(cpu_irq && cpu_idx == 2, "R7 before ack", cpu_idx, 2);
        cpu_ack = 1;
        @(negedge clk);
        cpu_ack = 0;
        @(negedge clk);
        check(cpu_irq && cpu_idx == 5, "R7 next after ack", cpu_idx, 5);
        rd(2'd0, d);
        check(d == 8'hA0, "R7 acked bit cleared", d, 8'hA0);

        // R8: set beats clear in the same cycle
        @(negedge clk);
        bus_we = 1; bus_addr = 2'd0; bus_wdata = 8'hA0; src_req = 8'h20;
        @(negedge clk);
        bus_we = 0; src_req = 0;
        rd(2'd0, d);
        check(d == 8'h20, "R8 set wins", d, 8'h20);

        // R9: pin register
        wr(2'd0, 8'hFF);
        @(negedge clk);
        pin_req = 4'hB;
        @(negedge clk);
        pin_req = 0;
        rd(2'd3, d);
        check(d == 8'h0B, "R9 pin capture", d, 8'h0B);
        wr(2'd3, 8'hF0);
        rd(2'd3, d);
        check(d == 8'h0B, "R9 reserved ignored", d, 8'h0B);
        wr(2'd3, 8'h01);
        rd(2'd3, d);
        check(d == 8'h0A, "R9 pin w1c", d, 8'h0A);
        @(negedge clk);
        check(cpu_irq == 0, "R9 pins not arbitrated", cpu_irq, 0);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule